// File: doc/BRIEF.md
# Iterative Integer Divider with Exception Flags

This unit divides one 32-bit integer by another over a fixed number of clock cycles. It works in either signed or unsigned mode. It returns a quotient and a remainder, together with two flags: one for a zero divisor and one for signed overflow. Internally it divides the operand magnitudes with a restoring shift-subtract loop, one quotient bit per cycle. When the loop finishes, it puts the signs back. The quotient is truncated toward zero, and the remainder carries the sign of the dividend.

**Input side.** Operands arrive on a valid/ready interface.
- An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` stays low for the whole time an operation is in flight.
- While `in_ready` is low, the caller must hold its request or repeat it later. A `in_valid` pulse presented then is dropped and has no effect.

**Output side.** The output side has no back-pressure.
- `out_valid` pulses for one cycle.
- The result registers keep their values until the next operation completes.

**Raw mode.** A raw-mode select skips the zero-divisor report. In raw mode the results are also copied into a paired result register: the remainder goes to `hi` and the quotient to `lo`.

Top module: `int_divider`

## Requirements
- R1: In signed mode (`is_signed`=1) the quotient is truncated toward zero and is negative when the operand signs differ. The remainder takes the dividend's sign. For example, -5 / 3 gives quotient -1 and remainder -2.
- R2: For a nonzero divisor, remainder = dividend - divisor * quotient, modulo 2^32.
- R3: In unsigned mode (`is_signed`=0) both operands are taken as unsigned 32-bit values.
- R4: In signed mode, dividing 0x80000000 by 0xFFFFFFFF sets `overflow`, and returns quotient 0x80000000 and remainder 0.
- R5: In checked mode (`raw_mode`=0), a zero divisor sets `div_zero`. The quotient is then all ones and the remainder equals the dividend.
- R6: In raw mode (`raw_mode`=1):
  - `div_zero` stays 0, even for a zero divisor.
  - At completion, `hi` receives the remainder and `lo` the quotient.
  - A checked-mode operation leaves `hi` and `lo` unchanged.
- R7: `overflow` is never set by an unsigned operation.
- R8: `in_ready` is low while an operation is in flight. An `in_valid` presented then is ignored, and the pending result is unaffected.
- R9: `out_valid` is high for exactly one cycle, 33 rising edges after the accepting edge. All result outputs hold their values until the next completion.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1. `quotient`, `remainder`, `hi`, `lo`, `div_zero` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand request |
| in_ready | output | 1 | Unit can accept a request |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| raw_mode | input | 1 | 1 = skip zero check and write hi/lo |
| out_valid | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in flight |
| quotient | output | 32 | Quotient of the last completed operation |
| remainder | output | 32 | Remainder of the last completed operation |
| div_zero | output | 1 | Zero divisor seen in checked mode |
| overflow | output | 1 | Signed most-negative by minus-one |
| hi | output | 32 | Remainder copy, written by raw-mode operations |
| lo | output | 32 | Quotient copy, written by raw-mode operations |

## Verification
All results, both flags and the `hi`/`lo` pair become valid together on the 33rd rising edge after acceptance. `out_valid` drops again on the 34th edge.

The bench drives each request half a period before the accepting edge. It then checks, on the falling edge after each of the first 32 edges, that `out_valid` is still low. On the falling edge after edge 33 it compares every output with a reference model. One falling edge later it confirms that the pulse has ended and the values are unchanged.

A request injected mid-operation is checked by confirming that the result still matches the first operand pair.

// File: rtl/div_pkg.sv
package div_pkg;

  // Per-operation control, captured when an operation is accepted
  typedef struct packed {
    logic neg_q;   // quotient must be negated
    logic neg_r;   // remainder must be negated
    logic zero;    // divisor was zero
    logic ovf;     // signed most-negative / minus-one
    logic sgn;     // signed mode
    logic raw;     // raw mode
  } div_ctl_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  input  logic         raw_mode,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output div_ctl_t     ctl
);

  localparam logic [W-1:0] MOST_NEG  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MINUS_ONE = {W{1'b1}};

  logic neg_a, neg_b;

  always_comb begin
    neg_a = is_signed & dividend[W-1];
    neg_b = is_signed & divisor[W-1];
    // The most-negative value negates to itself, which is its correct unsigned magnitude
    a_mag = neg_a ? (~dividend + 1'b1) : dividend;
    b_mag = neg_b ? (~divisor + 1'b1) : divisor;
    ctl.neg_q = neg_a ^ neg_b;
    ctl.neg_r = neg_a;
    ctl.zero  = (divisor == '0);
    ctl.ovf   = is_signed && (dividend == MOST_NEG) && (divisor == MINUS_ONE);
    ctl.sgn   = is_signed;
    ctl.raw   = raw_mode;
  end

endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_mag,
  input  logic [W-1:0] b_mag,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] q_mag,
  output logic [W-1:0] r_mag
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W:0]    rem;
  logic [W-1:0]  quo;
  logic [W-1:0]  dvs;
  logic [CW-1:0] cnt;
  logic          active;

  logic [W:0] shifted, trial;
  logic       take;

  always_comb begin
    shifted = {rem[W-1:0], quo[W-1]};
    trial   = shifted - {1'b0, dvs};
    take    = ~trial[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem    <= '0;
      quo    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
    end else if (start) begin
      rem    <= '0;
      quo    <= a_mag;
      dvs    <= b_mag;
      cnt    <= '0;
      active <= 1'b1;
      fin    <= 1'b0;
    end else if (active) begin
      rem <= take ? trial : shifted;
      quo <= {quo[W-2:0], take};
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        active <= 1'b0;
        fin    <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign busy  = active | fin;
  assign q_mag = quo;
  assign r_mag = rem[W-1:0];

  // R8: a new operation is only started while the loop is idle
  assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!active && !fin));

  // R9: the loop completion marker lasts a single cycle
  assert_fin_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  // R2: partial remainder stays below a nonzero divisor
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dvs != '0) |-> (rem < {1'b0, dvs}));

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  input  div_ctl_t     ctl,
  input  logic [W-1:0] dvd,
  output logic [W-1:0] q,
  output logic [W-1:0] r
);

  always_comb begin
    if (ctl.zero) begin
      // Deterministic zero-divisor results
      q = '1;
      r = dvd;
    end else begin
      q = ctl.neg_q ? (~q_mag + 1'b1) : q_mag;
      r = ctl.neg_r ? (~r_mag + 1'b1) : r_mag;
    end
  end

endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  input  logic         raw_mode,
  output logic         out_valid,
  output logic         busy,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero,
  output logic         overflow,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic         accept;
  logic [W-1:0] a_mag, b_mag;
  div_ctl_t     ctl_in, ctl_q;
  logic [W-1:0] dvd_q;
  logic         core_busy, core_fin;
  logic [W-1:0] q_mag, r_mag, q_fix, r_fix;

  assign in_ready = ~core_busy;
  assign busy     = core_busy;
  assign accept   = in_valid & in_ready;

  div_operand_prep #(.W(W)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .is_signed(is_signed),
    .raw_mode (raw_mode),
    .a_mag    (a_mag),
    .b_mag    (b_mag),
    .ctl      (ctl_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dvd_q <= '0;
    end else if (accept) begin
      ctl_q <= ctl_in;
      dvd_q <= dividend;
    end
  end

  div_core #(.W(W)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .a_mag(a_mag),
    .b_mag(b_mag),
    .busy (core_busy),
    .fin  (core_fin),
    .q_mag(q_mag),
    .r_mag(r_mag)
  );

  div_sign_fix #(.W(W)) u_fix (
    .q_mag(q_mag),
    .r_mag(r_mag),
    .ctl  (ctl_q),
    .dvd  (dvd_q),
    .q    (q_fix),
    .r    (r_fix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
      overflow  <= 1'b0;
      hi        <= '0;
      lo        <= '0;
    end else begin
      out_valid <= core_fin;
      if (core_fin) begin
        quotient  <= q_fix;
        remainder <= r_fix;
        div_zero  <= ctl_q.zero & ~ctl_q.raw;
        overflow  <= ctl_q.ovf;
        if (ctl_q.raw) begin
          hi <= r_fix;
          lo <= q_fix;
        end
      end
    end
  end

  // R9: completion pulse is one cycle wide
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9: results hold between completions
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_fin |=> ($stable(quotient) && $stable(remainder)));

  // R7: unsigned operations never flag overflow
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ctl_q.sgn) |-> !overflow);

  // R6: raw mode never reports a zero divisor
  assert_raw_no_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ctl_q.raw) |-> !div_zero);

  // R1: a nonzero signed remainder carries the dividend's sign
  assert_rem_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ctl_q.sgn && remainder != '0) |-> (remainder[W-1] == dvd_q[W-1]));

  // R4: overflow result is the most-negative quotient
  assert_ovf_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && overflow) |-> (quotient == MOST_NEG && remainder == '0));

endmodule

// File: tb/sim_int_divider.sv
module sim_int_divider;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        is_signed = 1'b0;
  logic        raw_mode = 1'b0;
  logic        out_valid, busy, div_zero, overflow;
  logic [31:0] quotient, remainder, hi, lo;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] exp_hi = '0;
  logic [31:0] exp_lo = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_divider #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .is_signed(is_signed), .raw_mode(raw_mode),
    .out_valid(out_valid), .busy(busy), .quotient(quotient), .remainder(remainder),
    .div_zero(div_zero), .overflow(overflow), .hi(hi), .lo(lo)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic s, input logic raw,
                                output logic [31:0] q, output logic [31:0] r,
                                output logic z, output logic o);
    longint sa, sb;
    z = 1'b0;
    o = 1'b0;
    if (b == 32'd0) begin
      q = 32'hFFFF_FFFF;
      r = a;
      z = ~raw;
    end else if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q = 32'(sa / sb);
      r = 32'(sa % sb);
      o = (a == 32'h8000_0000) && (b == 32'hFFFF_FFFF);
    end else begin
      q = a / b;
      r = a % b;
    end
  endfunction

  task automatic do_op(input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic raw, input bit intrude);
    logic [31:0] eq, er;
    logic ez, eo;
    bit early;
    string qt;
    model(a, b, s, raw, eq, er, ez, eo);
    if (b == 0)      qt = raw ? "R6" : "R5";
    else if (eo)     qt = "R4";
    else if (s)      qt = "R1";
    else             qt = "R3";
    @(negedge clk);
    check("R8", "in_ready idle", {31'd0, in_ready}, 32'd1);
    dividend = a; divisor = b; is_signed = s; raw_mode = raw; in_valid = 1'b1;
    @(negedge clk);                     // after accepting edge
    if (intrude) begin
      dividend = ~a; divisor = 32'd3; is_signed = ~s; raw_mode = ~raw;
      check("R8", "in_ready busy", {31'd0, in_ready}, 32'd0);
    end else begin
      in_valid = 1'b0;
    end
    early = 0;
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      if (k == 1) in_valid = 1'b0;
      if (out_valid) early = 1;
    end
    check("R9", "out_valid early", {31'd0, early}, 32'd0);
    @(negedge clk);                     // after edge 33
    check("R9", "out_valid due", {31'd0, out_valid}, 32'd1);
    check(qt, "quotient", quotient, eq);
    check((b != 0) ? "R2" : qt, "remainder", remainder, er);
    check("R5", "div_zero", {31'd0, div_zero}, {31'd0, ez});
    check(s ? "R4" : "R7", "overflow", {31'd0, overflow}, {31'd0, eo});
    if (raw) begin exp_hi = er; exp_lo = eq; end
    check("R6", "hi", hi, exp_hi);
    check("R6", "lo", lo, exp_lo);
    @(negedge clk);
    check("R9", "out_valid drop", {31'd0, out_valid}, 32'd0);
    check("R9", "quotient hold", quotient, eq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R10", "in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "quotient", quotient, 32'd0);
    check("R10", "remainder", remainder, 32'd0);
    check("R10", "hi", hi, 32'd0);
    check("R10", "lo", lo, 32'd0);
    check("R10", "flags", {30'd0, div_zero, overflow}, 32'd0);

    // Directed corner cases
    do_op(-32'sd5, 32'd3, 1'b1, 1'b0, 1'b0);              // R1: -1 rem -2
    do_op(32'd5, -32'sd3, 1'b1, 1'b0, 1'b0);              // R1
    do_op(-32'sd5, -32'sd3, 1'b1, 1'b0, 1'b0);            // R1
    do_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0); // R4
    do_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0); // R3, R7
    do_op(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0);        // R3
    do_op(32'd7, 32'd100, 1'b0, 1'b0, 1'b0);              // R3 small dividend
    do_op(32'd1234, 32'd0, 1'b1, 1'b0, 1'b0);             // R5
    do_op(-32'sd99, 32'd0, 1'b0, 1'b1, 1'b0);             // R6 raw zero
    do_op(32'd100, 32'd7, 1'b0, 1'b1, 1'b0);              // R6 raw hi/lo
    do_op(32'd50, 32'd6, 1'b1, 1'b0, 1'b0);               // R6 checked leaves hi/lo
    do_op(32'd1000, 32'd9, 1'b0, 1'b0, 1'b1);             // R8 request while busy
    do_op(-32'sd1000, 32'd9, 1'b1, 1'b1, 1'b1);           // R8

    // Constrained random
    for (int i = 0; i < 150; i++) begin
      ra = $urandom();
      case ($urandom_range(3))
        0: rb = $urandom_range(15);
        1: rb = -$urandom_range(15);
        2: rb = $urandom() >> $urandom_range(31);
        default: rb = $urandom();
      endcase
      if ($urandom_range(15) == 0) rb = 32'd0;
      do_op(ra, rb, 1'($urandom_range(1)), 1'($urandom_range(1)), ($urandom_range(7) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule